// File: doc/BRIEF.md
# Packed Shift, Pack and Align Unit

This block reformats packed 32-bit data. Each accepted request carries two operands (`src_a` and `src_b`), an amount (an immediate, or for the lane shifts the low bits of `src_a`) and a 4-bit operation code. One cycle later the block presents a registered 32-bit result, with `out_valid` high for that one cycle.

The operations fall into three groups. The lane shifts work on each byte or halfword lane on its own. The word shift-and-pack shifts two full words and keeps the low half of each. The merges pick bytes, or join bit or byte fields from the two operands. Rounding shifts add back the last bit that the shift discards. An operation code outside the defined set gives a zero result and raises `illegal_op`.

Top module: `pkalign_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `illegal_op` and `result` all become 0.
- R2: A request with `in_valid` high is reflected at the outputs after the next rising edge, with `out_valid` high for exactly that cycle. When `in_valid` is low, `out_valid` drops and `result` keeps its last value.
- R3: Code 0 shifts each of the four bytes of `src_b` right arithmetically (sign fill) by an amount of 0 to 7. The immediate form uses `imm_amt[2:0]`, and an amount of 0 returns the byte unchanged.
- R4: Code 1 is the same as code 0 with rounding. When the amount n is non-zero and bit n-1 of the original byte is 1, the shifted byte is incremented, kept to 8 bits.
- R5: When `use_reg_amt` is 1, the byte shifts (codes 0, 1) take their amount from `src_a[2:0]` and the halfword shift (code 2) from `src_a[3:0]`. Higher bits of `src_a` and all of `imm_amt` are ignored. Other codes always use `imm_amt`.
- R6: Code 2 shifts each halfword of `src_b` right logically (zero fill) by 0 to 15. The immediate form uses `imm_amt[3:0]`.
- R7: Codes 3 (plain) and 4 (rounding) shift `src_b` and `src_a` right arithmetically by `imm_amt` (0 to 31), rounding the same way as R4. Bits 31:16 take the low half of the shifted `src_b`, and bits 15:0 take the low half of the shifted `src_a`.
- R8: Code 5 returns {`src_a[23:16]`, `src_a[7:0]`, `src_b[23:16]`, `src_b[7:0]`}, from bit 31 down to bit 0.
- R9: Code 6 returns `src_b` shifted left by s = `imm_amt`, with its low s bits taken from the low s bits of `src_a`.
- R10: Code 7 returns (`src_a` << (32-s)) | (`src_b` >> s) for s = `imm_amt`, and returns `src_b` unchanged when s is 0.
- R11: Code 8 with p = `imm_amt[1:0]` returns (`src_b` << 8p) | (`src_a` >> 8(4-p)), and returns `src_b` unchanged when p is 0.
- R12: Codes 9 to 15 give a zero `result` with `illegal_op` high. `illegal_op` is high only in a cycle where `out_valid` is high, and a later legal request clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation code |
| use_reg_amt | input | 1 | Take lane-shift amount from `src_a` |
| imm_amt | input | 5 | Immediate shift amount or byte position |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |
| illegal_op | output | 1 | The code in the last request was undefined |

## Verification
The assertions cover the properties that hold on every cycle: the one-cycle valid timing, the holding of the result while idle, a zero result whenever the illegal flag is up, byte packing, and the pass-through of `src_b` for prepend and align with a zero amount. Rounding carries, sign fill at the extreme amounts, the ignored upper bits of a register amount, and the boundary amounts of append and word-pack can only be shown by the bench's vectors, which carry hand-computed expected words.

// File: rtl/pkalign_pkg.sv
package pkalign_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int OP_W   = 4;
    localparam int AMT_W  = $clog2(WORD_W);

    typedef enum logic [OP_W-1:0] {
        OP_BSRA      = 4'd0,
        OP_BSRA_RND  = 4'd1,
        OP_HSRL      = 4'd2,
        OP_WPACK     = 4'd3,
        OP_WPACK_RND = 4'd4,
        OP_BPACK     = 4'd5,
        OP_APPEND    = 4'd6,
        OP_PREPEND   = 4'd7,
        OP_BALIGN    = 4'd8
    } op_e;

    typedef struct packed {
        logic              illegal;
        logic [WORD_W-1:0] data;
    } res_t;

    // mask with the low n bits set
    function automatic logic [WORD_W-1:0] low_mask(input logic [AMT_W-1:0] n);
        logic [WORD_W-1:0] m;
        m = ~({WORD_W{1'b1}} << n);
        return m;
    endfunction

endpackage

// File: rtl/pkalign_lanes.sv
module pkalign_lanes #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter bit ARITH  = 1'b1
) (
    input  logic [WORD_W-1:0]         word_in,
    input  logic [$clog2(LANE_W)-1:0] amt,
    input  logic                      rnd,
    output logic [WORD_W-1:0]         word_out
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int AW    = $clog2(LANE_W);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        logic [LANE_W-1:0] shifted;
        logic [LANE_W-1:0] dropped;
        logic              carry;

        assign lane_in = word_in[g*LANE_W +: LANE_W];

        if (ARITH) begin : g_arith
            assign shifted = LANE_W'($signed(lane_in) >>> amt);
        end else begin : g_logic
            assign shifted = lane_in >> amt;
        end

        // last bit discarded by the shift sits at position amt-1
        assign dropped  = lane_in >> (amt - AW'(1));
        assign carry    = rnd && (amt != '0) && dropped[0];
        assign word_out[g*LANE_W +: LANE_W] = shifted + LANE_W'(carry);
    end

endmodule

// File: rtl/pkalign_merge.sv
module pkalign_merge
    import pkalign_pkg::*;
(
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [AMT_W-1:0]  amt,
    output logic [WORD_W-1:0] pack_res,
    output logic [WORD_W-1:0] append_res,
    output logic [WORD_W-1:0] prepend_res,
    output logic [WORD_W-1:0] align_res
);
    logic [AMT_W:0] inv_amt;
    logic [AMT_W:0] align_lo;
    logic [AMT_W:0] align_hi;

    assign inv_amt  = (AMT_W+1)'(WORD_W) - {1'b0, amt};
    assign align_lo = {1'b0, amt[1:0], 3'b000};
    assign align_hi = (AMT_W+1)'(WORD_W) - align_lo;

    assign pack_res = {src_a[3*BYTE_W-1:2*BYTE_W], src_a[BYTE_W-1:0],
                       src_b[3*BYTE_W-1:2*BYTE_W], src_b[BYTE_W-1:0]};

    assign append_res = (src_b << amt) | (src_a & low_mask(amt));

    always_comb begin
        if (amt == '0) prepend_res = src_b;
        else           prepend_res = (src_a << inv_amt) | (src_b >> amt);
    end

    always_comb begin
        if (amt[1:0] == 2'b00) align_res = src_b;
        else                   align_res = (src_b << align_lo) | (src_a >> align_hi);
    end

endmodule

// File: rtl/pkalign_unit.sv
module pkalign_unit
    import pkalign_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op_sel,
    input  logic              use_reg_amt,
    input  logic [4:0]        imm_amt,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    output logic              out_valid,
    output logic [31:0]       result,
    output logic              illegal_op
);
    localparam int BAW = $clog2(BYTE_W);
    localparam int HAW = $clog2(HALF_W);

    op_e              op;
    logic [BAW-1:0]   byte_amt;
    logic [HAW-1:0]   half_amt;
    logic [WORD_W-1:0] byte_res, half_res, wsh_b, wsh_a;
    logic [WORD_W-1:0] pack_res, append_res, prepend_res, align_res;
    res_t             nxt;
    logic             valid_q, ill_q;
    logic [WORD_W-1:0] data_q;

    assign op       = op_e'(op_sel);
    assign byte_amt = use_reg_amt ? src_a[BAW-1:0] : imm_amt[BAW-1:0];
    assign half_amt = use_reg_amt ? src_a[HAW-1:0] : imm_amt[HAW-1:0];

    pkalign_lanes #(.WORD_W(WORD_W), .LANE_W(BYTE_W), .ARITH(1'b1)) u_byte (
        .word_in(src_b), .amt(byte_amt), .rnd(op == OP_BSRA_RND), .word_out(byte_res));

    pkalign_lanes #(.WORD_W(WORD_W), .LANE_W(HALF_W), .ARITH(1'b0)) u_half (
        .word_in(src_b), .amt(half_amt), .rnd(1'b0), .word_out(half_res));

    pkalign_lanes #(.WORD_W(WORD_W), .LANE_W(WORD_W), .ARITH(1'b1)) u_word_b (
        .word_in(src_b), .amt(imm_amt), .rnd(op == OP_WPACK_RND), .word_out(wsh_b));

    pkalign_lanes #(.WORD_W(WORD_W), .LANE_W(WORD_W), .ARITH(1'b1)) u_word_a (
        .word_in(src_a), .amt(imm_amt), .rnd(op == OP_WPACK_RND), .word_out(wsh_a));

    pkalign_merge u_merge (
        .src_a(src_a), .src_b(src_b), .amt(imm_amt),
        .pack_res(pack_res), .append_res(append_res),
        .prepend_res(prepend_res), .align_res(align_res));

    always_comb begin
        nxt = '0;
        case (op)
            OP_BSRA, OP_BSRA_RND:   nxt.data = byte_res;
            OP_HSRL:                nxt.data = half_res;
            OP_WPACK, OP_WPACK_RND: nxt.data = {wsh_b[HALF_W-1:0], wsh_a[HALF_W-1:0]};
            OP_BPACK:               nxt.data = pack_res;
            OP_APPEND:              nxt.data = append_res;
            OP_PREPEND:             nxt.data = prepend_res;
            OP_BALIGN:              nxt.data = align_res;
            default:                nxt.illegal = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ill_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= in_valid;
            ill_q   <= in_valid && nxt.illegal;
            if (in_valid) data_q <= nxt.data;
        end
    end

    assign out_valid  = valid_q;
    assign illegal_op = ill_q;
    assign result     = data_q;

    // R2
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R12
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (out_valid && result == '0));
    // R8
    byte_pack_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 4'd5) |=>
        result == {$past(src_a[23:16]), $past(src_a[7:0]),
                   $past(src_b[23:16]), $past(src_b[7:0])});
    // R10
    prepend_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 4'd7 && imm_amt == 5'd0) |=> result == $past(src_b));
    // R11
    align_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 4'd8 && imm_amt[1:0] == 2'd0) |=> result == $past(src_b));

endmodule

// File: tb/test_pkalign_unit.sv
module test_pkalign_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op_sel;
    logic        use_reg_amt;
    logic [4:0]  imm_amt;
    logic [31:0] src_a, src_b;
    logic        out_valid, illegal_op;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    pkalign_unit i_pkalign_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .use_reg_amt(use_reg_amt), .imm_amt(imm_amt), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .illegal_op(illegal_op));

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic        ureg;
        logic [4:0]  amt;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  4'd0, 1'b0, 5'd1,  32'h0,        32'h807F01FE, 32'hC03F00FF, 1'b0}, // R3
        '{8'd3,  4'd0, 1'b0, 5'd0,  32'h0,        32'h12345678, 32'h12345678, 1'b0}, // R3
        '{8'd3,  4'd0, 1'b0, 5'd7,  32'h0,        32'h807F40C0, 32'hFF0000FF, 1'b0}, // R3
        '{8'd4,  4'd1, 1'b0, 5'd1,  32'h0,        32'h807F01FE, 32'hC04001FF, 1'b0}, // R4
        '{8'd4,  4'd1, 1'b0, 5'd2,  32'h0,        32'hFF06827E, 32'h0002E120, 1'b0}, // R4
        '{8'd5,  4'd0, 1'b1, 5'd5,  32'hFFFFFFF9, 32'h807F01FE, 32'hC03F00FF, 1'b0}, // R5
        '{8'd6,  4'd2, 1'b0, 5'd4,  32'h0,        32'h8000FFFF, 32'h08000FFF, 1'b0}, // R6
        '{8'd6,  4'd2, 1'b0, 5'd15, 32'h0,        32'hFFFF7FFF, 32'h00010000, 1'b0}, // R6
        '{8'd5,  4'd2, 1'b1, 5'd9,  32'h00000013, 32'hF0F01234, 32'h1E1E0246, 1'b0}, // R5
        '{8'd7,  4'd3, 1'b0, 5'd0,  32'h11112222, 32'h33334444, 32'h44442222, 1'b0}, // R7
        '{8'd7,  4'd3, 1'b0, 5'd4,  32'h00012340, 32'h87654321, 32'h54321234, 1'b0}, // R7
        '{8'd7,  4'd4, 1'b0, 5'd4,  32'hFFFFFFF7, 32'h00000018, 32'h0002FFFF, 1'b0}, // R7
        '{8'd7,  4'd4, 1'b0, 5'd31, 32'h80000000, 32'h40000000, 32'h0001FFFF, 1'b0}, // R7
        '{8'd8,  4'd5, 1'b0, 5'd0,  32'hAABBCCDD, 32'h11223344, 32'hBBDD2244, 1'b0}, // R8
        '{8'd9,  4'd6, 1'b0, 5'd8,  32'hAABBCCDD, 32'h12345678, 32'h345678DD, 1'b0}, // R9
        '{8'd9,  4'd6, 1'b0, 5'd0,  32'hAABBCCDD, 32'h12345678, 32'h12345678, 1'b0}, // R9
        '{8'd9,  4'd6, 1'b0, 5'd31, 32'hAABBCCDD, 32'h12345679, 32'hAABBCCDD, 1'b0}, // R9
        '{8'd10, 4'd7, 1'b0, 5'd8,  32'hAABBCCDD, 32'h12345678, 32'hDD123456, 1'b0}, // R10
        '{8'd10, 4'd7, 1'b0, 5'd0,  32'hAABBCCDD, 32'h12345678, 32'h12345678, 1'b0}, // R10
        '{8'd11, 4'd8, 1'b0, 5'd1,  32'hAABBCCDD, 32'h12345678, 32'h345678AA, 1'b0}, // R11
        '{8'd11, 4'd8, 1'b0, 5'd3,  32'hAABBCCDD, 32'h12345678, 32'h78AABBCC, 1'b0}, // R11
        '{8'd11, 4'd8, 1'b0, 5'd4,  32'hAABBCCDD, 32'h12345678, 32'h12345678, 1'b0}, // R11
        '{8'd12, 4'd9, 1'b0, 5'd3,  32'hAABBCCDD, 32'h12345678, 32'h00000000, 1'b1}, // R12
        '{8'd12, 4'd15,1'b0, 5'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1}  // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic send(input logic [3:0] op, input logic ureg, input logic [4:0] amt,
                        input logic [31:0] a, input logic [31:0] b);
        op_sel = op; use_reg_amt = ureg; imm_amt = amt; src_a = a; src_b = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; use_reg_amt = 1'b0;
        imm_amt = '0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 illegal_op", 32'(illegal_op), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].op, VECS[i].ureg, VECS[i].amt, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].exp);
            check($sformatf("R%0d vec%0d illegal", VECS[i].req, i),
                  32'(illegal_op), 32'(VECS[i].ill));
            check($sformatf("R2 vec%0d valid", i), 32'(out_valid), 32'd1);
        end

        // R2: valid drops and result holds when idle, even with changed inputs
        src_a = 32'hDEADBEEF; src_b = 32'hCAFEF00D; op_sel = 4'd5;
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 32'd0);
        check("R2 idle hold", result, 32'h00000000);
        check("R12 idle illegal", 32'(illegal_op), 32'd0);

        // R12: a legal request after an illegal one clears the flag
        send(4'd10, 1'b0, 5'd0, 32'h1, 32'h1);
        check("R12 illegal set", 32'(illegal_op), 32'd1);
        send(4'd5, 1'b0, 5'd0, 32'hDEADBEEF, 32'hCAFEF00D);
        check("R12 illegal cleared", 32'(illegal_op), 32'd0);
        check("R8 pack", result, 32'hADEFFE0D);

        // R5: register form ignores imm_amt and upper src_a bits for halfwords
        send(4'd2, 1'b1, 5'd0, 32'hFFFFFFF1, 32'h80008000);
        check("R5 half reg amt", result, 32'h40004000);

        // R1: reset in mid-run clears outputs
        send(4'd6, 1'b0, 5'd4, 32'hF, 32'h1);
        check("R9 append", result, 32'h0000001F);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset result", result, 32'd0);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        finish_up();
    end

endmodule